// File: doc/BRIEF.md
# Sequenced-Command Watchdog Timer

This block is a watchdog countdown timer controlled through a single 32-bit control word. Every write to the word stores a new reload value and presents two 2-bit command fields. One field starts or stops the timer. The other restarts the countdown.

A command field acts only when software writes the value 1 to it and then the value 2 to it on the following write. A single stray write therefore cannot change the timer. The start/stop command is a toggle. The reload value sets the upper part of the count, and the low 8 bits of the loaded count are zero.

A read returns the stored reload value and a status bit that is set while the timer runs. When a running count expires, the `timeout_o` output pulses. The counter then restarts from the reload value.

Top module: `wdt_seq_ctrl`

## Requirements
- R1: After reset `rst_ni` is asserted (asynchronous, active low), the timer is stopped, both command trackers are idle, `rd_data_o` reads zero and `timeout_o` is low.
- R2: Each write stores `wr_data_i[23:0]` as the reload value. The value reads back on `rd_data_o[23:0]` from the cycle after the write. Without a write it does not change.
- R3: Bits 30:24 of `rd_data_o` always read zero, whatever was written to bits 31:24.
- R4: Bits 25:24 form the start/stop field. A write of 1 followed, on the next write that carries a non-zero value in that field, by a write of 2 toggles the running state. `rd_data_o[31]` reads 1 while the timer runs.
- R5: A field value of 0 leaves that field's tracker unchanged. After a 1, any value other than 2 (that is, 1 or 3) returns the tracker to idle without a command. In the idle state, 2 or 3 does nothing.
- R6: When the timer starts, the count is loaded with reload<<8 (L). `timeout_o` is high for exactly one cycle, L+1 cycles after the starting write, and again every L+1 cycles after that. With L = 0 it stays high on every cycle.
- R7: Bits 27:26 form the reload field, which uses the same 1-then-2 rule. When this command completes while the timer runs, the count is reloaded, and the next timeout comes L+1 cycles after the completing write.
- R8: A completed reload command while the timer is stopped has no effect: the timer stays stopped and no timeout occurs.
- R9: A stopped timer never asserts `timeout_o`.
- R10: If one write completes a stop and a reload command at the same time, the stop wins: the timer stops and no timeout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word written when the strobe is high |
| rd_data_o | output | 32 | Status bit 31 and reload value 23:0 |
| timeout_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench builds the block with its default widths: a 32-bit counter and a 24-bit reload field, so the shift is 8. Small reload values such as 1 and 2 give expiry periods of 257 and 513 cycles. These let the bench observe several full expiries, a reload that postpones an expiry, and the zero-reload case, where the timer expires on every cycle. A behavioural model that uses integer state is compared with both outputs on every clock. Directed checks also sample the exact cycle of each expected pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int unsigned REG_W    = 32;
  parameter int unsigned EN_LSB   = 24;  // start/stop field, reload field sits above it
  parameter int unsigned SRV_LSB  = 26;
  parameter int unsigned STAT_BIT = 31;
  parameter int unsigned NUM_CMD  = 2;   // index 0: start/stop, index 1: reload

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ARMED = 1'b1} seq_state_e;
  typedef logic [1:0] cmd_field_t;

  localparam cmd_field_t CMD_NOP  = 2'd0;
  localparam cmd_field_t CMD_ARM  = 2'd1;
  localparam cmd_field_t CMD_FIRE = 2'd2;
endpackage

// File: rtl/wdt_cmd_seq.sv
module wdt_cmd_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  cmd_field_t field_i,
  output logic       fire_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    if (wr_i && field_i != CMD_NOP) begin
      if (state_q == SEQ_IDLE) begin
        state_d = (field_i == CMD_ARM) ? SEQ_ARMED : SEQ_IDLE;
      end else begin
        state_d = SEQ_IDLE;
        fire_o  = (field_i == CMD_FIRE);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned RELOAD_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tgl_i,
  input  logic                srv_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                en_o,
  output logic                timeout_o
);
  localparam int unsigned SHIFT = CNT_W - RELOAD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;
  logic             en_q, en_d, tmo_d;

  assign load_val = {reload_i, {SHIFT{1'b0}}};

  // stop beats reload; any completed command suppresses expiry that cycle
  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    tmo_d = 1'b0;
    if (tgl_i) begin
      en_d = !en_q;
      if (!en_q) cnt_d = load_val;
    end else if (en_q) begin
      if (srv_i) begin
        cnt_d = load_val;
      end else if (cnt_q == '0) begin
        tmo_d = 1'b1;
        cnt_d = load_val;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      en_q      <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      en_q      <= en_d;
      timeout_o <= tmo_d;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/wdt_seq_ctrl.sv
module wdt_seq_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned RELOAD_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             timeout_o
);
  logic [RELOAD_W-1:0] reload_q, reload_d;
  logic [NUM_CMD-1:0]  fire;
  logic                en;
  logic                unused_hi;

  assign unused_hi = ^wr_data_i[REG_W-1:SRV_LSB+2];

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_seq
    wdt_cmd_seq u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i),
      .field_i (wr_data_i[EN_LSB+2*g +: 2]),
      .fire_o  (fire[g])
    );
  end

  assign reload_d = wr_en_i ? wr_data_i[RELOAD_W-1:0] : reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reload_q <= '0;
    else         reload_q <= reload_d;
  end

  wdt_down_cnt #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tgl_i     (fire[0]),
    .srv_i     (fire[1]),
    .reload_i  (reload_d),
    .en_o      (en),
    .timeout_o (timeout_o)
  );

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[RELOAD_W-1:0]   = reload_q;
    rd_data_o[STAT_BIT]       = en;
  end
endmodule

// File: rtl/wdt_seq_ctrl_chk.sv
module wdt_seq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  en_field_i,
  input logic [31:0] rd_data_o,
  input logic        timeout_o
);
  // R9: an expiry pulse needs a running timer in the cycle before
  a_r9_no_tmo_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(rd_data_o[31]));

  // R6: pulse lasts one cycle when the loaded count is non-zero
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && rd_data_o[23:0] != 24'd0) |=> !timeout_o);

  // R4: running state changes only on a write
  a_r4_toggle_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] != $past(rd_data_o[31])) |-> $past(wr_en_i));

  // R4: the toggling write carried the value 2 in the start/stop field
  a_r4_toggle_on_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31] != $past(rd_data_o[31])) |-> ($past(en_field_i) == 2'd2));

  // R2: reload value holds without a write
  a_r2_reload_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(rd_data_o[23:0]));
endmodule

bind wdt_seq_ctrl wdt_seq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .en_field_i (wr_data_i[25:24]),
  .rd_data_o  (rd_data_o),
  .timeout_o  (timeout_o)
);

// File: tb/wdt_seq_ctrl_tb.sv
module wdt_seq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  wdt_seq_ctrl u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .timeout_o (timeout_o)
  );

  // behavioural reference model
  bit      m_en, m_tmo;
  longint  m_cnt;
  int      m_rel;
  int      m_st [2];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_tmo = 0; m_cnt = 0; m_rel = 0; m_st[0] = 0; m_st[1] = 0;
    end else begin
      bit fire [2];
      longint ld;
      fire[0] = 0; fire[1] = 0;
      if (wr_en_i) begin
        m_rel = int'(wr_data_i[23:0]);
        for (int i = 0; i < 2; i++) begin
          int f;
          f = int'(wr_data_i[24+2*i +: 2]);
          if (f != 0) begin
            if (m_st[i] == 0) m_st[i] = (f == 1) ? 1 : 0;
            else begin fire[i] = (f == 2); m_st[i] = 0; end
          end
        end
      end
      ld = longint'(m_rel) * 256;
      m_tmo = 0;
      if (fire[0]) begin
        if (!m_en) m_cnt = ld;
        m_en = !m_en;
      end else if (m_en) begin
        if (fire[1]) m_cnt = ld;
        else if (m_cnt == 0) begin m_tmo = 1; m_cnt = ld; end
        else m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 R6 per-cycle comparison with the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [31:0] exp_rd;
      exp_rd = {m_en, 7'b0, m_rel[23:0]};
      chk(rd_data_o == exp_rd, "R2 model rd_data", rd_data_o, exp_rd);
      chk(timeout_o == m_tmo, "R6 model timeout", timeout_o, m_tmo);
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [31:0] word(input int srv, input int en, input int rel);
    return {4'b0, 2'(srv), 2'(en), 24'(rel)};
  endfunction

  task automatic no_tmo_for(input int n, input string tag);
    int seen = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (timeout_o) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(rd_data_o == 32'h0, "R1 reset rd_data", rd_data_o, 0);
    chk(timeout_o == 1'b0, "R1 reset timeout", timeout_o, 0);
    rst_ni = 1'b1;

    wr(32'h0000_0005);
    chk(rd_data_o == 32'h5, "R2 reload readback", rd_data_o, 5);
    wait_neg(3);
    chk(rd_data_o == 32'h5, "R2 reload holds", rd_data_o, 5);

    wr(32'h7000_0007);
    chk(rd_data_o[30:24] == 7'h0, "R3 high bits zero", rd_data_o[30:24], 0);
    chk(rd_data_o[31] == 1'b0, "R3 status not writable", rd_data_o[31], 0);

    // R4 start with L = 256
    wr(word(0, 1, 1));
    chk(rd_data_o[31] == 1'b0, "R4 no toggle after 1 only", rd_data_o[31], 0);
    wr(word(0, 2, 1));
    chk(rd_data_o[31] == 1'b1, "R4 started", rd_data_o[31], 1);
    wait_neg(256);
    chk(timeout_o == 1'b0, "R6 not before L+1", timeout_o, 0);
    wait_neg(1);
    chk(timeout_o == 1'b1, "R6 pulse at L+1", timeout_o, 1);
    wait_neg(1);
    chk(timeout_o == 1'b0, "R6 pulse one cycle", timeout_o, 0);
    wait_neg(256);
    chk(timeout_o == 1'b1, "R6 periodic", timeout_o, 1);

    // R7 reload postpones expiry
    wait_neg(100);
    wr(word(1, 0, 1));
    wr(word(2, 0, 1));
    wait_neg(256);
    chk(timeout_o == 1'b0, "R7 postponed", timeout_o, 0);
    wait_neg(1);
    chk(timeout_o == 1'b1, "R7 pulse after reload", timeout_o, 1);

    // R5 broken sequences
    wr(word(0, 1, 1)); wr(word(0, 3, 1)); wr(word(0, 2, 1));
    chk(rd_data_o[31] == 1'b1, "R5 1-3-2 ignored", rd_data_o[31], 1);
    wr(word(0, 1, 1)); wr(word(0, 1, 1)); wr(word(0, 2, 1));
    chk(rd_data_o[31] == 1'b1, "R5 1-1-2 ignored", rd_data_o[31], 1);
    wr(word(0, 2, 1));
    chk(rd_data_o[31] == 1'b1, "R5 idle 2 ignored", rd_data_o[31], 1);
    wr(word(0, 1, 1)); wr(word(0, 0, 1)); wr(word(0, 2, 1));
    chk(rd_data_o[31] == 1'b0, "R5 zero keeps armed", rd_data_o[31], 0);

    // R9 stopped
    no_tmo_for(600, "R9 stopped no timeout");

    // R8 reload while stopped
    wr(word(1, 0, 1)); wr(word(2, 0, 1));
    chk(rd_data_o[31] == 1'b0, "R8 stays stopped", rd_data_o[31], 0);
    no_tmo_for(300, "R8 no timeout");

    // R10 stop beats reload
    wr(word(0, 1, 2)); wr(word(0, 2, 2));
    chk(rd_data_o[31] == 1'b1, "R10 started", rd_data_o[31], 1);
    wr(word(1, 1, 2)); wr(word(2, 2, 2));
    chk(rd_data_o[31] == 1'b0, "R10 stop wins", rd_data_o[31], 0);
    no_tmo_for(600, "R10 no timeout");

    // R6 zero reload expires every cycle
    wr(word(0, 1, 0)); wr(word(0, 2, 0));
    begin
      int hi = 0;
      repeat (5) begin @(negedge clk_i); if (timeout_o) hi++; end
      chk(hi == 5, "R6 zero reload continuous", hi, 5);
    end

    // R1 reset while running
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk(rd_data_o == 32'h0, "R1 reset while running", rd_data_o, 0);
    chk(timeout_o == 1'b0, "R1 timeout cleared", timeout_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule